// File: doc/BRIEF.md
# Learning Layer-2 Forwarding Engine

This block makes the egress decision for one frame header at a time. A request carries the destination address, the source address and the port the frame came in on. The engine looks the destination up in a small associative table. On a match it returns the single port stored in that entry. On a miss it returns a flood mask. Each request also teaches the table where its source address lives.

Requests are accepted with a valid/ready handshake. The decision is registered and appears one clock after acceptance. The table holds a fixed number of entries, each with an address, a port and a valid bit. A known address is refreshed in place. A new address fills the lowest empty entry. Once every entry is in use, a rotating pointer selects which entry a new address overwrites. Frame buffering, payload movement and timed ageing are handled elsewhere.

Top module: `l2_fwd_engine`

## Requirements
- R1: When the destination matches a valid entry whose port differs from the ingress port, `rsp_mask` has only bit p set, where p is the stored port and bit i of the mask stands for port i. `rsp_hit` is 1.
- R2: When the destination matches no valid entry, `rsp_mask` has every port bit set except the ingress port bit, and `rsp_hit` is 0.
- R3: When the destination matches an entry whose stored port equals the ingress port, `rsp_mask` is all zeros and `rsp_hit` is 1.
- R4: A destination of all ones always gives the flood mask of R2 with `rsp_hit` = 0, whatever the table holds.
- R5: The source address of every accepted frame is stored against that frame's ingress port, so a later frame sent to it is forwarded to that port.
- R6: Learning an address that is already in the table changes the stored port in place and uses no second entry.
- R7: A new address goes to the lowest-indexed empty entry. When the table is full, it overwrites the entry chosen by a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, on each overwrite only.
- R8: A source address of all ones is never learned.
- R9: A frame's lookup sees the table as it was before that frame's own learn write.
- R10: A frame is accepted when `req_valid` and `req_ready` are both 1 at a clock edge. `rsp_valid` is 1 for exactly the one cycle after each acceptance and 0 otherwise. `req_ready` is 0 while in reset and 1 from the first clock edge after reset is released.
- R11: Reset empties the table, so every destination misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request header present |
| req_ready | output | 1 | Engine can take a header |
| req_dst | input | ADDR_W | Destination address |
| req_src | input | ADDR_W | Source address |
| req_port | input | PORT_W | Ingress port number |
| rsp_valid | output | 1 | Decision valid, one cycle |
| rsp_hit | output | 1 | Destination found in table |
| rsp_mask | output | NUM_PORTS | Egress port mask, bit i for port i |

## Verification
The assertions assume that `req_port` is always below NUM_PORTS, because the ingress-exclusion property indexes the mask with it. They also assume that the request fields matter only in a cycle where `req_valid` is high. The stimulus uses only ports 0 to 3 with a four-port build. It changes inputs only at falling edges and holds `req_valid` low between directed phases. The address sequence is chosen to fill the table, force wrapping replacement, move known addresses between ports, and send a frame whose destination equals its own new source.

// File: rtl/l2fwd_pkg.sv
package l2fwd_pkg;

  // Kind of write the learn path performs for the current frame.
  typedef enum logic [1:0] {
    LRN_NONE   = 2'd0,
    LRN_UPDATE = 2'd1,
    LRN_FILL   = 2'd2,
    LRN_EVICT  = 2'd3
  } lrn_act_e;

endpackage

// File: rtl/l2_prio_enc.sv
module l2_prio_enc #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // Lowest set bit wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/l2_addr_table.sv
module l2_addr_table
  import l2fwd_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 48,
  parameter int PORT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              look_hit,
  output logic [PORT_W-1:0] look_port,
  input  logic              lrn_en,
  input  logic [ADDR_W-1:0] lrn_addr,
  input  logic [PORT_W-1:0] lrn_port
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ADDR_W-1:0]  ent_addr [ENTRIES];
  logic [PORT_W-1:0]  ent_port [ENTRIES];
  logic [ENTRIES-1:0] ent_valid;

  logic [ENTRIES-1:0] dst_match;
  logic [ENTRIES-1:0] src_match;
  logic [ENTRIES-1:0] free_vec;
  logic [ENTRIES-1:0] wr_sel;

  logic             dst_found, src_found, free_found;
  logic [IDX_W-1:0] dst_idx, src_idx, free_idx;

  logic [IDX_W-1:0] rr_q, rr_d;
  logic             rr_en;
  lrn_act_e         act;
  logic [IDX_W-1:0] wr_idx;

  // Per-entry comparators and write selects.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign dst_match[g] = ent_valid[g] && (ent_addr[g] == look_addr);
    assign src_match[g] = ent_valid[g] && (ent_addr[g] == lrn_addr);
    assign free_vec[g]  = ~ent_valid[g];
    assign wr_sel[g]    = (act != LRN_NONE) && (wr_idx == IDX_W'(g));
  end

  l2_prio_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_dst_enc (
    .req_vec (dst_match),
    .found   (dst_found),
    .idx     (dst_idx)
  );

  l2_prio_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_src_enc (
    .req_vec (src_match),
    .found   (src_found),
    .idx     (src_idx)
  );

  l2_prio_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_free_enc (
    .req_vec (free_vec),
    .found   (free_found),
    .idx     (free_idx)
  );

  // Lookup reads the registered table contents.
  assign look_hit  = dst_found;
  assign look_port = ent_port[dst_idx];

  // Learn decision: refresh, fill, or evict at the rotating pointer.
  always_comb begin
    act    = LRN_NONE;
    wr_idx = rr_q;
    rr_d   = rr_q;
    rr_en  = 1'b0;
    if (lrn_en) begin
      if (src_found) begin
        act    = LRN_UPDATE;
        wr_idx = src_idx;
      end else if (free_found) begin
        act    = LRN_FILL;
        wr_idx = free_idx;
      end else begin
        act    = LRN_EVICT;
        wr_idx = rr_q;
        rr_en  = 1'b1;
        rr_d   = (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (rr_en) begin
      rr_q <= rr_d;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_valid[g] <= 1'b0;
      end else if (wr_sel[g]) begin
        ent_valid[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_sel[g]) begin
        ent_addr[g] <= lrn_addr;
        ent_port[g] <= lrn_port;
      end
    end
  end

endmodule

// File: rtl/l2_mask_gen.sv
module l2_mask_gen #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 2
) (
  input  logic                 bcast,
  input  logic                 tbl_hit,
  input  logic [PORT_W-1:0]    tbl_port,
  input  logic [PORT_W-1:0]    ingress,
  output logic                 hit,
  output logic [NUM_PORTS-1:0] mask
);

  localparam logic [NUM_PORTS-1:0] ALL_PORTS = '1;

  logic [NUM_PORTS-1:0] ingress_oh;
  logic [NUM_PORTS-1:0] egress_oh;

  assign ingress_oh = NUM_PORTS'(1) << ingress;
  assign egress_oh  = NUM_PORTS'(1) << tbl_port;

  always_comb begin
    if (!bcast && tbl_hit) begin
      hit  = 1'b1;
      mask = egress_oh & ~ingress_oh;
    end else begin
      hit  = 1'b0;
      mask = ALL_PORTS & ~ingress_oh;
    end
  end

endmodule

// File: rtl/l2_fwd_engine.sv
module l2_fwd_engine #(
  parameter int NUM_PORTS = 4,
  parameter int ENTRIES   = 8,
  parameter int ADDR_W    = 48,
  parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_dst,
  input  logic [ADDR_W-1:0]    req_src,
  input  logic [PORT_W-1:0]    req_port,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic [NUM_PORTS-1:0] rsp_mask
);

  logic                 fire;
  logic                 dst_bcast, src_bcast;
  logic                 tbl_hit;
  logic [PORT_W-1:0]    tbl_port;
  logic                 dec_hit;
  logic [NUM_PORTS-1:0] dec_mask;

  logic                 ready_q;
  logic                 vld_q, vld_d;
  logic                 hit_q;
  logic [NUM_PORTS-1:0] mask_q;

  assign fire      = req_valid && ready_q;
  assign dst_bcast = &req_dst;
  assign src_bcast = &req_src;

  l2_addr_table #(
    .ENTRIES (ENTRIES),
    .ADDR_W  (ADDR_W),
    .PORT_W  (PORT_W)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_addr (req_dst),
    .look_hit  (tbl_hit),
    .look_port (tbl_port),
    .lrn_en    (fire && !src_bcast),
    .lrn_addr  (req_src),
    .lrn_port  (req_port)
  );

  l2_mask_gen #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W)
  ) u_mask (
    .bcast    (dst_bcast),
    .tbl_hit  (tbl_hit),
    .tbl_port (tbl_port),
    .ingress  (req_port),
    .hit      (dec_hit),
    .mask     (dec_mask)
  );

  assign vld_d = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      vld_q   <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      mask_q <= '0;
    end else if (fire) begin
      hit_q  <= dec_hit;
      mask_q <= dec_mask;
    end
  end

  assign req_ready = ready_q;
  assign rsp_valid = vld_q;
  assign rsp_hit   = hit_q;
  assign rsp_mask  = mask_q;

endmodule

// File: rtl/l2_fwd_engine_chk.sv
module l2_fwd_engine_chk #(
  parameter int NUM_PORTS = 4,
  parameter int ENTRIES   = 8,
  parameter int ADDR_W    = 48,
  parameter int PORT_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [ADDR_W-1:0]    req_dst,
  input logic [ADDR_W-1:0]    req_src,
  input logic [PORT_W-1:0]    req_port,
  input logic                 rsp_valid,
  input logic                 rsp_hit,
  input logic [NUM_PORTS-1:0] rsp_mask
);

  logic acc;
  assign acc = req_valid && req_ready;

  AST_RSP_FOLLOWS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid); // R10

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid); // R10

  AST_INGRESS_EXCLUDED: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (((rsp_mask >> $past(req_port)) & NUM_PORTS'(1)) == '0)); // R2

  AST_HIT_SINGLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> $onehot0(rsp_mask)); // R1

  AST_MISS_FLOOD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> ($countones(rsp_mask) == NUM_PORTS - 1)); // R2

  AST_BCAST_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (&req_dst)) |=> !rsp_hit); // R4

endmodule

bind l2_fwd_engine l2_fwd_engine_chk #(
  .NUM_PORTS (NUM_PORTS),
  .ENTRIES   (ENTRIES),
  .ADDR_W    (ADDR_W),
  .PORT_W    (PORT_W)
) u_chk (.*);

// File: tb/l2_fwd_engine_bench.sv
module l2_fwd_engine_bench;

  localparam int NP  = 4;
  localparam int NE  = 4;
  localparam int AW  = 48;
  localparam int PW  = 2;
  localparam int VW  = AW + AW + PW + NP + 1;
  localparam int NV  = 18;
  localparam logic [AW-1:0] BC = '1;

  // {dst, src, ingress, expected mask, expected hit}
  localparam logic [VW-1:0] VECS [NV] = '{
    {48'h0A, 48'h01, 2'd0, 4'b1110, 1'b0},  // R2 miss, R5 learn 01@0
    {48'h01, 48'h02, 2'd1, 4'b0001, 1'b1},  // R1 R5
    {48'h02, 48'h01, 2'd0, 4'b0010, 1'b1},  // R1
    {48'h01, 48'h03, 2'd0, 4'b0000, 1'b1},  // R3 filter
    {BC,     48'h04, 2'd2, 4'b1011, 1'b0},  // R4, table full
    {48'h03, BC,     2'd3, 4'b0001, 1'b1},  // R8 bcast src not learned
    {BC,     48'h02, 2'd3, 4'b0111, 1'b0},  // R4, R6 02 moves to 3
    {48'h02, 48'h01, 2'd1, 4'b1000, 1'b1},  // R6 check move, 01 to 1
    {48'h05, 48'h06, 2'd2, 4'b1011, 1'b0},  // R7 evict entry 0
    {48'h01, 48'h07, 2'd0, 4'b1110, 1'b0},  // R7 01 gone, evict entry 1
    {48'h06, 48'h03, 2'd1, 4'b0100, 1'b1},  // R7 R6 03 to 1
    {48'h02, 48'h07, 2'd3, 4'b0111, 1'b0},  // R7 02 gone
    {48'h04, 48'h08, 2'd0, 4'b0100, 1'b1},  // R7 evict entry 2
    {48'h03, 48'h08, 2'd1, 4'b1101, 1'b0},  // R7 03 gone, R6 08 to 1
    {48'h07, 48'h09, 2'd1, 4'b1000, 1'b1},  // R7 evict entry 3
    {48'h08, 48'h09, 2'd2, 4'b0010, 1'b1},  // R6 08 kept single entry
    {48'h0B, 48'h0B, 2'd2, 4'b1011, 1'b0},  // R9 lookup before own learn
    {48'h0B, 48'h09, 2'd0, 4'b0100, 1'b1}   // R9 R7 0B landed at wrap
  };

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_dst;
  logic [AW-1:0] req_src;
  logic [PW-1:0] req_port;
  logic          rsp_valid;
  logic          rsp_hit;
  logic [NP-1:0] rsp_mask;

  int n_run;
  int n_fail;
  bit done;

  l2_fwd_engine #(
    .NUM_PORTS (NP),
    .ENTRIES   (NE),
    .ADDR_W    (AW),
    .PORT_W    (PW)
  ) u_l2_fwd_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_dst   (req_dst),
    .req_src   (req_src),
    .req_port  (req_port),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_mask  (rsp_mask)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [AW-1:0] d, input logic [AW-1:0] s, input logic [PW-1:0] p);
    req_valid = 1'b1;
    req_dst   = d;
    req_src   = s;
    req_port  = p;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run     = 0;
    n_fail    = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_dst   = '0;
    req_src   = '0;
    req_port  = '0;

    repeat (3) @(negedge clk);
    check("R10 ready low in reset", 32'(req_ready), 32'd0);
    check("R11 rsp_valid low in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ready high after reset", 32'(req_ready), 32'd1);
    check("R10 idle no response", 32'(rsp_valid), 32'd0);

    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] v;
      v = VECS[k];
      drive(v[VW-1 -: AW], v[VW-1-AW -: AW], v[NP+1 +: PW]);
      @(negedge clk);
      check($sformatf("R10 vec%0d valid", k), 32'(rsp_valid), 32'd1);
      check($sformatf("R1-tab vec%0d mask", k), 32'(rsp_mask), 32'(v[NP:1]));
      check($sformatf("R2-tab vec%0d hit", k), 32'(rsp_hit), 32'(v[0]));
    end

    req_valid = 1'b0;
    @(negedge clk);
    check("R10 valid drops after one cycle", 32'(rsp_valid), 32'd0);

    // R11: reset in the middle clears learned entries
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 valid cleared by reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    drive(48'h09, 48'h0C, 2'd0);
    @(negedge clk);
    check("R11 known addr misses after reset", 32'(rsp_mask), 32'b1110);
    check("R11 hit flag after reset", 32'(rsp_hit), 32'd0);
    // R5 after reset: 0C learned on port 0
    drive(48'h0C, 48'h0D, 2'd3);
    @(negedge clk);
    check("R5 relearn after reset", 32'(rsp_mask), 32'b0001);
    req_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule